// File: doc/BRIEF.md
# Output Set/Reset Parallel Port

This block is the general-purpose parallel I/O section of a dual-channel serial controller. It keeps an output latch that the host never writes as a whole. One write address turns on the latch bits that are ones in the data byte. A second address turns off the bits that are ones in the data byte. Software can therefore change single pins without a read-modify-write sequence. Each output pin drives the inverse of its latch bit, so setting a bit pulls its pin low.

A configuration register chooses, pin by pin, whether the pin follows the manual latch or an internal function source. In this block every internal source is tied to the idle (high) level. The input pins are active low. They pass through a two-flop synchronizer and are read back at the same address that, on a write, loads the configuration register.

Top module: `gpio_sr_port`

## Requirements
- R1: After reset the latch and the configuration register are zero, so every output pin is high.
- R2: A write to offset 0xE sets each latch bit whose data bit is 1 and leaves the other latch bits unchanged.
- R3: A write to offset 0xF clears each latch bit whose data bit is 1 and leaves the other latch bits unchanged.
- R4: A pin whose configuration bit is 0 drives the inverse of its latch bit (latch bit 1 gives pin low).
- R5: A write to offset 0xD loads the configuration register. A pin whose configuration bit is 1 drives the idle high level whatever its latch holds.
- R6: A read at offset 0xD returns the input pin levels as they were two clock edges earlier. Pins are not inverted and bit i is pin i.
- R7: A write to any offset other than 0xD, 0xE or 0xF changes neither the latch nor the configuration register.
- R8: A read cycle (select high, write enable low) at any offset changes no state. A read at any offset other than 0xD returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write enable for the access |
| bus_addr_i | input | 4 | Register offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, combinational from state |
| in_pins_i | input | 8 | Input port pins, active low |
| out_pins_o | output | 8 | Output port pins |

## Verification
A write is taken on the rising edge where select and write enable are both high. Its effect on the output pins is visible after that same edge. The bench therefore checks the pins at the falling edge that follows. A change on an input pin appears on the read data only after two rising edges. The bench checks the read data at the falling edge after the first rising edge, where it must still show the old value, and again after the second, where it must show the new value. The read data is combinational, so reads are checked during the access cycle itself.

// File: rtl/gpio_sr_pkg.sv
package gpio_sr_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] OFS_CFG_IN = 4'hD;
  localparam logic [ADDR_W-1:0] OFS_SET    = 4'hE;
  localparam logic [ADDR_W-1:0] OFS_CLR    = 4'hF;

  typedef struct packed {
    logic wr_cfg;
    logic wr_set;
    logic wr_clr;
    logic rd_in;
  } strobe_t;
endpackage

// File: rtl/gpio_sr_decode.sv
module gpio_sr_decode
  import gpio_sr_pkg::*;
(
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output strobe_t           strb_o
);
  always_comb begin
    strb_o        = '0;
    strb_o.wr_cfg = sel_i &  we_i & (addr_i == OFS_CFG_IN);
    strb_o.wr_set = sel_i &  we_i & (addr_i == OFS_SET);
    strb_o.wr_clr = sel_i &  we_i & (addr_i == OFS_CLR);
    strb_o.rd_in  = sel_i & ~we_i & (addr_i == OFS_CFG_IN);
  end
endmodule

// File: rtl/gpio_sr_regs.sv
module gpio_sr_regs #(
  parameter int N_OUT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_set_i,
  input  logic             wr_clr_i,
  input  logic             wr_cfg_i,
  input  logic [N_OUT-1:0] data_i,
  output logic [N_OUT-1:0] latch_o,
  output logic [N_OUT-1:0] cfg_o
);
  logic [N_OUT-1:0] latch_q, cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      latch_q <= '0;
    end else if (wr_set_i) begin
      latch_q <= latch_q | data_i;
    end else if (wr_clr_i) begin
      latch_q <= latch_q & ~data_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else if (wr_cfg_i) cfg_q <= data_i;
  end

  assign latch_o = latch_q;
  assign cfg_o   = cfg_q;

  AST_SET_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set_i |=> ((latch_q & $past(data_i)) == $past(data_i))) else $error("set"); // R2
  AST_SET_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set_i |=> ((latch_q & ~$past(data_i)) == ($past(latch_q) & ~$past(data_i)))) else $error("set keep"); // R2
  AST_CLR_ZEROS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr_i |=> ((latch_q & $past(data_i)) == '0)) else $error("clr"); // R3
  AST_CLR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr_i |=> ((latch_q & ~$past(data_i)) == ($past(latch_q) & ~$past(data_i)))) else $error("clr keep"); // R3
  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_set_i && !wr_clr_i) |=> $stable(latch_q)) else $error("latch hold"); // R7
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_cfg_i |=> $stable(cfg_q)) else $error("cfg hold"); // R7
endmodule

// File: rtl/gpio_sr_insync.sv
module gpio_sr_insync #(
  parameter int N_IN = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_IN-1:0] pins_i,
  output logic [N_IN-1:0] sync_o
);
  logic [N_IN-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '1;
      sync_q <= '1;
    end else begin
      meta_q <= pins_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;

  // edges seen since reset, saturating at 2
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else if (age_q != 2'd2) age_q <= age_q + 2'd1;
  end

  AST_SYNC_DEPTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (sync_q == $past(pins_i, 2))) else $error("sync"); // R6
endmodule

// File: rtl/gpio_sr_port.sv
module gpio_sr_port
  import gpio_sr_pkg::*;
#(
  parameter int N_OUT = 8,
  parameter int N_IN  = 8,
  parameter logic ALT_IDLE = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_sel_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [N_IN-1:0]   in_pins_i,
  output logic [N_OUT-1:0]  out_pins_o
);
  strobe_t          strb;
  logic [N_OUT-1:0] latch, cfg;
  logic [N_IN-1:0]  in_sync;

  gpio_sr_decode u_dec (
    .sel_i  (bus_sel_i),
    .we_i   (bus_we_i),
    .addr_i (bus_addr_i),
    .strb_o (strb)
  );

  gpio_sr_regs #(.N_OUT(N_OUT)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_set_i (strb.wr_set),
    .wr_clr_i (strb.wr_clr),
    .wr_cfg_i (strb.wr_cfg),
    .data_i   (bus_wdata_i[N_OUT-1:0]),
    .latch_o  (latch),
    .cfg_o    (cfg)
  );

  gpio_sr_insync #(.N_IN(N_IN)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pins_i (in_pins_i),
    .sync_o (in_sync)
  );

  // alternate function sources are tied to the idle level
  for (genvar i = 0; i < N_OUT; i++) begin : g_pin
    assign out_pins_o[i] = cfg[i] ? ALT_IDLE : ~latch[i];
  end

  always_comb begin
    bus_rdata_o = '0;
    if (strb.rd_in) bus_rdata_o[N_IN-1:0] = in_sync;
  end

  AST_RESET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (out_pins_o == '1)) else $error("reset idle"); // R1
  AST_READ_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_sel_i && !bus_we_i) |=> $stable(out_pins_o)) else $error("read side effect"); // R8
  AST_RDATA_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_addr_i != OFS_CFG_IN) |-> (bus_rdata_o == '0)) else $error("rdata"); // R8
endmodule

// File: tb/gpio_sr_port_test.sv
`timescale 1ns/1ps
module gpio_sr_port_test;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       sel = 0, we = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic [7:0] in_pins = 8'hFF, out_pins;

  logic [7:0] latch_m = 0, cfg_m = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_sr_port uut (
    .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .in_pins_i(in_pins), .out_pins_o(out_pins)
  );

  function automatic logic [7:0] exp_pins(logic [7:0] l, logic [7:0] c);
    logic [7:0] p;
    for (int i = 0; i < 8; i++) p[i] = c[i] ? 1'b1 : ~l[i];
    return p;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [3:0] a, logic [7:0] d, string req);
    @(negedge clk);
    sel = 1; we = 1; addr = a; wdata = d;
    @(negedge clk);
    sel = 0; we = 0;
    case (a)
      4'hD: cfg_m = d;
      4'hE: latch_m = latch_m | d;
      4'hF: latch_m = latch_m & ~d;
      default: ;
    endcase
    check(req, out_pins, exp_pins(latch_m, cfg_m));
  endtask

  task automatic bus_read(logic [3:0] a, logic [7:0] exp, string req);
    @(negedge clk);
    sel = 1; we = 0; addr = a; wdata = 8'hFF;
    #1 check(req, rdata, exp);
    @(negedge clk);
    sel = 0;
    check("R8 read leaves pins", out_pins, exp_pins(latch_m, cfg_m));
  endtask

  // R6: old value one edge after a change, new value after two
  task automatic input_step(logic [7:0] v);
    logic [7:0] old;
    old = in_pins;
    @(negedge clk);
    in_pins = v;
    sel = 1; we = 0; addr = 4'hD;
    @(negedge clk);
    #1 check("R6 one edge", rdata, old);
    @(negedge clk);
    #1 check("R6 two edges", rdata, v);
    sel = 0;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    check("R1 pins low-before-release", out_pins, 8'hFF);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset pins", out_pins, 8'hFF);
    bus_read(4'hD, 8'hFF, "R6 reset input");

    // directed corners
    bus_write(4'hE, 8'hA5, "R2 set pattern");
    bus_write(4'hE, 8'h00, "R2 set zero");
    bus_write(4'hF, 8'h5A, "R3 clear unset bits");
    bus_write(4'hF, 8'h81, "R3 clear some");
    bus_write(4'hE, 8'hFF, "R4 all set, pins low");
    bus_write(4'hD, 8'hF0, "R5 cfg upper idle");
    bus_write(4'hD, 8'hFF, "R5 cfg all idle");
    bus_write(4'hD, 8'h00, "R5 cfg back to latch");
    bus_write(4'h3, 8'h00, "R7 stray write");
    bus_write(4'hC, 8'hFF, "R7 stray write");
    bus_write(4'hF, 8'hFF, "R3 clear all");
    bus_read(4'hE, 8'h00, "R8 read other offset");
    input_step(8'h3C);
    input_step(8'hC3);

    for (int n = 0; n < 400; n++) begin
      int op;
      logic [7:0] d;
      op = int'($urandom_range(0, 9));
      d = 8'($urandom);
      case (op)
        0, 1, 2: bus_write(4'hE, d, "R2 random set");
        3, 4, 5: bus_write(4'hF, d, "R3 random clear");
        6:       bus_write(4'hD, d & 8'($urandom), "R5 random cfg");
        7:       bus_write(4'($urandom_range(0, 12)), d, "R7 random stray");
        8:       bus_read(4'($urandom_range(0, 15)) == 4'hD ? 4'h0 : 4'($urandom_range(0, 12)),
                          8'h00, "R8 random read");
        default: input_step(d);
      endcase
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule